// File: doc/BRIEF.md
# Single-Wire Slave ROM Command Layer

This block is the addressing layer of a slave on a single-wire multidrop bus. It sits above a bit-slot engine. That engine reports three events: a bus reset, each bit the master writes, and each read slot in which the slave may answer. The slave can only pull the line low. To send a 0 it asserts its drive output, and to send a 1 it leaves the line released.

Each bus reset produces a one-cycle presence request. The layer then collects an 8-bit command, least significant bit first. Four commands are recognised:

- Read the 64-bit identity.
- Compare the identity against an address the master sends.
- Join the bitwise tree search, one slot triplet per identity bit.
- Become selected without any address.

When addressing succeeds, a select flag is raised for the memory-function layer above. That flag stays up until the next bus reset. A slave that fails a comparison, drops out of the search, or receives an unknown command goes silent until the next bus reset.

The 64-bit identity is supplied on a port. It holds the family code in bits 7:0, the serial number in bits 55:8 and the check byte in bits 63:56. It is always sent and compared from bit 0 upward.

Top module: `swr_rom_layer`

## Requirements
- R1: The cycle after `bus_reset_i` is sampled high, `presence_o` is high for exactly one cycle and `selected_o` is low. A bus reset in any state abandons the current command and restarts the command phase.
- R2: After a bus reset, the next 8 bits on `rx_bit_i` (qualified by `rx_valid_i`) form the command code, first bit as bit 0. `drive_low_o` stays low during the command phase.
- R3: Command 33h: for read slot k (k = 0..63), `drive_low_o` is high before the slot exactly when `id_i[k]` is 0.
- R4: After the 64th read slot of command 33h, `selected_o` goes high.
- R5: Command 55h: if the 64 received bits equal `id_i[0]`..`id_i[63]` in that order, `selected_o` goes high after the last bit.
- R6: Command 55h: if any received bit differs, `selected_o` stays low and `drive_low_o` stays low until the next bus reset.
- R7: Command F0h: for each bit k, the first read slot sends `id_i[k]`, the second sends its complement, and then one written bit is taken from the master.
- R8: During the search, a written bit that differs from `id_i[k]` makes the slave leave the search. It drives nothing in later slots and stays unselected until the next bus reset.
- R9: A slave that passes all 64 search triplets is selected.
- R10: Command CCh raises `selected_o` in the cycle after its eighth bit, with no address.
- R11: Any other command code leaves the slave silent and unselected until the next bus reset.
- R12: Once raised, `selected_o` holds until the next bus reset, and a selected slave never asserts `drive_low_o`.
- R13: After the power-on reset and before the first bus reset, written bits and read slots have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset_i | input | 1 | One-cycle pulse: bus reset detected |
| rx_valid_i | input | 1 | One-cycle pulse: master wrote a bit |
| rx_bit_i | input | 1 | Value of the written bit |
| rd_slot_i | input | 1 | One-cycle pulse: a read slot consumed the current drive value |
| id_i | input | 64 | Device identity, bit 0 sent first |
| presence_o | output | 1 | One-cycle request to answer with presence |
| drive_low_o | output | 1 | Pull the line low in the next read slot |
| selected_o | output | 1 | Device addressed; memory layer may proceed |

## Verification
The hardest case to reach is a slave leaving the search part way through. That only happens when another device on the bus has a different bit at the same position and the master branches toward that device. The bench models a second slave whose identity differs at one position. It forms the wired-AND of both drives in each read slot and lets the master pick the peer's branch when both reads come back 0. It then checks that the block goes silent for every remaining triplet and is never selected.

// File: rtl/swr_pkg.sv
package swr_pkg;

  localparam int unsigned CMD_W = 8;

  localparam logic [CMD_W-1:0] CODE_READ_ID = 8'h33;
  localparam logic [CMD_W-1:0] CODE_MATCH   = 8'h55;
  localparam logic [CMD_W-1:0] CODE_SEARCH  = 8'hF0;
  localparam logic [CMD_W-1:0] CODE_SKIP    = 8'hCC;

  typedef enum logic [2:0] {
    ST_WAIT      = 3'd0,
    ST_CMD       = 3'd1,
    ST_READ      = 3'd2,
    ST_MATCH     = 3'd3,
    ST_SRCH_TRUE = 3'd4,
    ST_SRCH_CMPL = 3'd5,
    ST_SRCH_WR   = 3'd6,
    ST_SEL       = 3'd7
  } swr_state_e;

endpackage

// File: rtl/swr_cmd_rx.sv
module swr_cmd_rx #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic         done_o,
  output logic [W-1:0] code_o
);
  localparam int unsigned CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  sr_q, sr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          en;

  assign code_o = {bit_i, sr_q[W-1:1]};
  assign done_o = shift_i && (cnt_q == LAST);
  assign en     = clear_i || shift_i;

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    if (clear_i) begin
      sr_d  = '0;
      cnt_d = '0;
    end else if (shift_i) begin
      sr_d  = code_o;
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (en) begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/swr_bit_index.sv
module swr_bit_index #(
  parameter int unsigned N = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear_i,
  input  logic                 step_i,
  output logic [$clog2(N)-1:0] idx_o,
  output logic                 last_o
);
  localparam int unsigned IW = $clog2(N);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  logic [IW-1:0] idx_q, idx_d;
  logic          en;

  assign idx_o  = idx_q;
  assign last_o = (idx_q == LAST);
  assign en     = clear_i || step_i;

  always_comb begin
    idx_d = idx_q;
    if (clear_i)     idx_d = '0;
    else if (step_i) idx_d = last_o ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  idx_q <= '0;
    else if (en) idx_q <= idx_d;
  end
endmodule

// File: rtl/swr_id_pick.sv
module swr_id_pick #(
  parameter int unsigned N = 64
) (
  input  logic [N-1:0]         id_i,
  input  logic [$clog2(N)-1:0] idx_i,
  output logic                 bit_o
);
  assign bit_o = id_i[idx_i];
endmodule

// File: rtl/swr_rom_layer.sv
module swr_rom_layer
  import swr_pkg::*;
#(
  parameter int unsigned ID_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_reset_i,
  input  logic            rx_valid_i,
  input  logic            rx_bit_i,
  input  logic            rd_slot_i,
  input  logic [ID_W-1:0] id_i,
  output logic            presence_o,
  output logic            drive_low_o,
  output logic            selected_o
);
  localparam int unsigned IW = $clog2(ID_W);

  swr_state_e    state_q, state_d;
  logic          pres_q;
  logic          cmd_done;
  logic [CMD_W-1:0] cmd_code;
  logic [IW-1:0] idx;
  logic          idx_last;
  logic          cur_bit;
  logic          cmd_shift;
  logic          idx_clear;
  logic          idx_step;
  logic          bit_ok;

  // command receiver
  assign cmd_shift = (state_q == ST_CMD) && rx_valid_i && !bus_reset_i;

  swr_cmd_rx #(.W(CMD_W)) u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (bus_reset_i),
    .shift_i (cmd_shift),
    .bit_i   (rx_bit_i),
    .done_o  (cmd_done),
    .code_o  (cmd_code)
  );

  // identity bit position shared by read, match and search
  assign bit_ok = (rx_bit_i == cur_bit);

  always_comb begin
    idx_step = 1'b0;
    unique case (state_q)
      ST_READ:    idx_step = rd_slot_i;
      ST_MATCH:   idx_step = rx_valid_i && bit_ok;
      ST_SRCH_WR: idx_step = rx_valid_i && bit_ok;
      default:    idx_step = 1'b0;
    endcase
  end

  assign idx_clear = bus_reset_i || (state_q == ST_CMD);

  swr_bit_index #(.N(ID_W)) u_idx (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (idx_clear),
    .step_i  (idx_step),
    .idx_o   (idx),
    .last_o  (idx_last)
  );

  swr_id_pick #(.N(ID_W)) u_pick (
    .id_i  (id_i),
    .idx_i (idx),
    .bit_o (cur_bit)
  );

  // next state
  always_comb begin
    state_d = state_q;
    if (bus_reset_i) begin
      state_d = ST_CMD;
    end else begin
      unique case (state_q)
        ST_WAIT: state_d = ST_WAIT;
        ST_CMD: begin
          if (cmd_done) begin
            unique case (cmd_code)
              CODE_READ_ID: state_d = ST_READ;
              CODE_MATCH:   state_d = ST_MATCH;
              CODE_SEARCH:  state_d = ST_SRCH_TRUE;
              CODE_SKIP:    state_d = ST_SEL;
              default:      state_d = ST_WAIT;
            endcase
          end
        end
        ST_READ: begin
          if (rd_slot_i && idx_last) state_d = ST_SEL;
        end
        ST_MATCH: begin
          if (rx_valid_i) begin
            if (!bit_ok)       state_d = ST_WAIT;
            else if (idx_last) state_d = ST_SEL;
          end
        end
        ST_SRCH_TRUE: begin
          if (rd_slot_i) state_d = ST_SRCH_CMPL;
        end
        ST_SRCH_CMPL: begin
          if (rd_slot_i) state_d = ST_SRCH_WR;
        end
        ST_SRCH_WR: begin
          if (rx_valid_i) begin
            if (!bit_ok)       state_d = ST_WAIT;
            else if (idx_last) state_d = ST_SEL;
            else               state_d = ST_SRCH_TRUE;
          end
        end
        ST_SEL:  state_d = ST_SEL;
        default: state_d = ST_WAIT;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      pres_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pres_q  <= bus_reset_i;
    end
  end

  // outputs
  always_comb begin
    unique case (state_q)
      ST_READ:      drive_low_o = !cur_bit;
      ST_SRCH_TRUE: drive_low_o = !cur_bit;
      ST_SRCH_CMPL: drive_low_o = cur_bit;
      default:      drive_low_o = 1'b0;
    endcase
  end

  assign presence_o = pres_q;
  assign selected_o = (state_q == ST_SEL);

endmodule

// File: rtl/swr_rom_checker.sv
module swr_rom_checker (
  input logic clk,
  input logic rst_n,
  input logic bus_reset_i,
  input logic rx_valid_i,
  input logic rd_slot_i,
  input logic presence_o,
  input logic drive_low_o,
  input logic selected_o
);
  AST_PRESENCE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_i |=> presence_o); // R1
  AST_PRESENCE_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    presence_o |-> $past(bus_reset_i)); // R1
  AST_RESET_DESELECTS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_i |=> !selected_o); // R1
  AST_CMD_PHASE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    presence_o |-> !drive_low_o); // R2
  AST_SELECT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (selected_o && !bus_reset_i) |=> selected_o); // R12
  AST_SELECTED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    selected_o |-> !drive_low_o); // R12
  AST_SELECT_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(selected_o) |-> $past(rx_valid_i || rd_slot_i)); // R10
endmodule

bind swr_rom_layer swr_rom_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_reset_i (bus_reset_i),
  .rx_valid_i  (rx_valid_i),
  .rd_slot_i   (rd_slot_i),
  .presence_o  (presence_o),
  .drive_low_o (drive_low_o),
  .selected_o  (selected_o)
);

// File: tb/swr_rom_layer_test.sv
module swr_rom_layer_test;
  localparam logic [63:0] ID_A = 64'h9E3C_5A17_D20B_8136;
  localparam int DROP_K = 5;
  localparam logic [63:0] ID_PEER = ID_A ^ (64'h1 << DROP_K);

  logic clk, rst_n, bus_reset, rx_valid, rx_bit, rd_slot;
  logic presence, drive_low, selected;
  int checks = 0, fails = 0;

  swr_rom_layer uut (
    .clk (clk), .rst_n (rst_n), .bus_reset_i (bus_reset),
    .rx_valid_i (rx_valid), .rx_bit_i (rx_bit), .rd_slot_i (rd_slot),
    .id_i (ID_A), .presence_o (presence), .drive_low_o (drive_low),
    .selected_o (selected)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_rst();
    bus_reset = 1'b1;
    @(negedge clk) bus_reset = 1'b0;
    chk(presence === 1'b1, "R1 presence", presence, 1);
    chk(selected === 1'b0, "R1 deselect", selected, 0);
    @(negedge clk);
    chk(presence === 1'b0, "R1 presence one cycle", presence, 0);
  endtask

  task automatic send_bit(input logic b);
    rx_valid = 1'b1; rx_bit = b;
    @(negedge clk) rx_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      chk(drive_low === 1'b0, "R2 silent in command", drive_low, 0);
      send_bit(v[i]);
    end
  endtask

  // returns the level this slave leaves on the line (1 = released)
  task automatic read_slot(output logic lvl);
    lvl = ~drive_low;
    rd_slot = 1'b1;
    @(negedge clk) rd_slot = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_power_on();
    logic l;
    chk(selected === 1'b0 && presence === 1'b0 && drive_low === 1'b0,
        "R13 reset state", {selected, presence, drive_low}, 0);
    for (int i = 0; i < 8; i++) send_bit(swr_pkg::CODE_SKIP[i]);
    read_slot(l);
    chk(selected === 1'b0, "R13 skip before bus reset", selected, 0);
    chk(l === 1'b1, "R13 no drive before bus reset", l, 1);
  endtask

  task automatic t_read_id();
    logic [63:0] got;
    logic l;
    bus_rst();
    send_byte(8'h33);
    for (int k = 0; k < 64; k++) begin
      chk(selected === 1'b0, "R3 not selected while reading", selected, 0);
      read_slot(l);
      got[k] = l;
    end
    chk(got === ID_A, "R3 identity read", got, ID_A);
    chk(selected === 1'b1, "R4 selected after read", selected, 1);
    read_slot(l);
    chk(l === 1'b1, "R12 selected is silent", l, 1);
    bus_rst();
    chk(selected === 1'b0, "R12 bus reset clears select", selected, 0);
  endtask

  task automatic t_match_ok();
    bus_rst();
    send_byte(8'h55);
    for (int k = 0; k < 64; k++) begin
      if (k == 63) chk(selected === 1'b0, "R5 not before last bit", selected, 0);
      send_bit(ID_A[k]);
    end
    chk(selected === 1'b1, "R5 match selects", selected, 1);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    chk(selected === 1'b1, "R12 select holds", selected, 1);
  endtask

  task automatic t_match_bad();
    logic l;
    bus_rst();
    send_byte(8'h55);
    for (int k = 0; k < 64; k++) send_bit(k == 40 ? ~ID_A[k] : ID_A[k]);
    chk(selected === 1'b0, "R6 mismatch not selected", selected, 0);
    read_slot(l);
    chk(l === 1'b1, "R6 mismatch silent", l, 1);
  endtask

  task automatic t_skip();
    bus_rst();
    send_byte(8'hCC);
    chk(selected === 1'b1, "R10 skip selects", selected, 1);
  endtask

  task automatic t_unknown();
    logic l;
    bus_rst();
    send_byte(8'hA5);
    read_slot(l);
    chk(l === 1'b1, "R11 unknown silent", l, 1);
    for (int i = 0; i < 8; i++) send_bit(swr_pkg::CODE_SKIP[i]);
    chk(selected === 1'b0, "R11 unknown not selected", selected, 0);
  endtask

  task automatic t_search_alone();
    logic t, c;
    int bad = 0;
    bus_rst();
    send_byte(8'hF0);
    for (int k = 0; k < 64; k++) begin
      read_slot(t);
      read_slot(c);
      if (t !== ID_A[k] || c !== ~ID_A[k]) bad++;
      send_bit(ID_A[k]);
    end
    chk(bad == 0, "R7 true and complement slots", bad, 0);
    chk(selected === 1'b1, "R9 search completes", selected, 1);
  endtask

  task automatic t_search_drop();
    logic t, c, bt, bc, pick;
    int late = 0;
    bus_rst();
    send_byte(8'hF0);
    for (int k = 0; k < 64; k++) begin
      read_slot(t);
      read_slot(c);
      bt = t & ID_PEER[k];
      bc = c & ~ID_PEER[k];
      if (k == DROP_K) begin
        chk(t === ID_A[k] && c === ~ID_A[k], "R7 slots at branch", {t, c},
            {ID_A[k], ~ID_A[k]});
        chk(bt === 1'b0 && bc === 1'b0, "R7 wired-AND conflict", {bt, bc}, 0);
      end
      if (k > DROP_K && (t !== 1'b1 || c !== 1'b1)) late++;
      pick = (bt == 1'b0 && bc == 1'b0) ? ID_PEER[k] : bt;
      send_bit(pick);
    end
    chk(late == 0, "R8 silent after drop", late, 0);
    chk(selected === 1'b0, "R8 dropped not selected", selected, 0);
  endtask

  task automatic t_abort();
    bus_rst();
    send_byte(8'h55);
    for (int k = 0; k < 10; k++) send_bit(ID_A[k]);
    bus_rst();
    send_byte(8'hCC);
    chk(selected === 1'b1, "R1 reset restarts command", selected, 1);
    bus_rst();
    send_bit(1'b1);
    bus_rst();
    send_byte(8'hCC);
    chk(selected === 1'b1, "R2 partial command discarded", selected, 1);
  endtask

  initial begin
    rst_n = 1'b0; bus_reset = 1'b0; rx_valid = 1'b0; rx_bit = 1'b0;
    rd_slot = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_power_on();
    t_read_id();
    t_match_ok();
    t_match_bad();
    t_skip();
    t_unknown();
    t_search_alone();
    t_search_drop();
    t_abort();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule